// File: doc/BRIEF.md
# Single-Precision Rounding and Packing Stage

This block is the last stage of a binary32 floating-point datapath. Upstream logic supplies the sign of the exact result, a signed biased exponent with headroom, and a normalized 27-bit significand. The significand holds a hidden bit, 23 fraction bits, a guard bit, a round bit and a sticky bit. The block denormalizes tiny values, rounds in one of five modes, handles the carry out of rounding, and packs the 32-bit word. It also raises the overflow, underflow and inexact flags.

Special operands are classified upstream. The block is only told, through two flags, when the result is a NaN or an infinity, and it passes those through. The rounding mode comes from a run-time input, or from a parameter when `DYN_RM` is 0. Results are registered, so each output appears one clock after its inputs.

Top module: `fp32_rounder`

## Requirements
- R1: When `nan_i` is high, the result is 0x7FC00000 and all three flags are low, whatever the other inputs are.
- R2: When `inf_i` is high (and `nan_i` is low), the result is {sign, 0xFF, 0}. When `sig_i` is zero, the result is {sign, 0x00, 0}. In both cases all flags are low.
- R3: Mode code 0 (nearest, ties to even) rounds the kept significand to the nearest value and breaks exact ties toward an even LSB. A value 1.5 ulp above magnitude 0x40C00000 gives 0x40C00002, and one 0.5 ulp above 0x40C00000 gives 0x40C00000.
- R4: Mode code 1 (nearest, ties away) rounds to the nearest value and breaks ties away from zero. The 0.5 ulp case above 0x40C00000 gives 0x40C00001.
- R5: Mode codes 2 (toward +inf) and 3 (toward -inf) move any inexact value up in magnitude only when the sign matches the direction. In code 2 the 1.5 ulp case gives 0x40C00002 for a positive sign and 0x40C00001 for a negative sign. Code 3 gives the reverse.
- R6: Mode code 4 (toward zero) truncates, so the 1.5 ulp case gives 0x40C00001. Codes 5 to 7 behave as code 4.
- R7: When the rounded biased exponent reaches 255 or more, `of_o` and `nx_o` are both high. The result is infinity for codes 0 and 1. For code 2 it is +infinity when positive and 0xFF7FFFFF when negative. For code 3 it is 0x7F7FFFFF when positive and -infinity when negative. For code 4 it is the largest finite value with the result's sign.
- R8: `nx_o` is high exactly when any bit below the kept 24-bit significand is non-zero, counting bits shifted out during denormalization.
- R9: When `exp_i` is 0 or below, the significand is shifted right by 1 - `exp_i` with sticky collection, and the result is encoded with exponent field 0. `uf_o` is high exactly when the rounded result has exponent field 0 and is inexact. `uf_o` implies `nx_o`.
- R10: A carry out of rounding increments the exponent. An all-ones fraction at exponent 254 that rounds up overflows, and a subnormal that rounds up to the hidden bit becomes 0x00800000 with `uf_o` low.
- R11: Each output reflects the inputs sampled one rising clock edge earlier. While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rmode_i | input | 3 | Rounding mode code (0..4; 5..7 act as 4), used when DYN_RM=1 |
| nan_i | input | 1 | Result is NaN |
| inf_i | input | 1 | Result is infinity |
| sign_i | input | 1 | Result sign |
| exp_i | input | EXP_W (10) | Signed biased exponent of the hidden bit |
| sig_i | input | 27 | Hidden bit, 23 fraction bits, guard, round, sticky |
| result_o | output | 32 | Packed binary32 result |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |

## Verification
Directed ties at 0.5 and 1.5 ulp above 6.0, with both signs and every mode code, separate ties-to-even from ties-away and the two directed modes from each other and from truncation. Overflow stimulus comes in two forms: an exponent pushed past the top by the rounding carry, and an exponent already too large. Both are tried in every mode and with both signs, which exposes the sign-dependent choice between infinity and the largest finite value. Stimulus near and far below the normal range exercises sticky collection in the shift, the subnormal-to-normal carry and the underflow flag. Seeded random operands over all modes, with exponents from deep underflow to overflow, are compared against a model that decides rounding by comparing the discarded remainder with half an ulp.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int FRAC_W  = 23;
  localparam int EXPF_W  = 8;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int EXT_W   = 3;
  localparam int SIG_W   = MANT_W + EXT_W;
  localparam int EXP_TOP = (1 << EXPF_W) - 1;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_NEAR_AWAY = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_ZERO      = 3'd4
  } rmode_e;

  function automatic logic rnd_up(rmode_e rm, logic s, logic lsb, logic g, logic st);
    case (rm)
      RM_NEAR_EVEN: return g & (st | lsb);
      RM_NEAR_AWAY: return g;
      RM_UP:        return ~s & (g | st);
      RM_DOWN:      return s & (g | st);
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ovf_word(rmode_e rm, logic s);
    logic to_inf;
    case (rm)
      RM_NEAR_EVEN, RM_NEAR_AWAY: to_inf = 1'b1;
      RM_UP:                      to_inf = ~s;
      RM_DOWN:                    to_inf = s;
      default:                    to_inf = 1'b0;
    endcase
    return to_inf ? {s, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                  : {s, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  endfunction
endpackage

// File: rtl/fpr_denorm.sv
module fpr_denorm
  import fpr_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    tiny_o
);
  localparam int SH_W = $clog2(SIG_W);

  logic signed [EXP_W:0] sh_full;
  logic [SH_W-1:0]       sh;
  logic [SIG_W-1:0]      lost_mask;

  assign tiny_o    = (exp_i <= 0);
  assign sh_full   = (EXP_W+1)'(1) - {exp_i[EXP_W-1], exp_i};
  assign sh        = sh_full[SH_W-1:0];
  assign lost_mask = ~({SIG_W{1'b1}} << sh);

  always_comb begin
    if (!tiny_o)
      sig_o = sig_i;
    else if (sh_full >= (EXP_W+1)'(SIG_W))
      sig_o = {{(SIG_W-1){1'b0}}, |sig_i};
    else
      sig_o = (sig_i >> sh) | {{(SIG_W-1){1'b0}}, |(sig_i & lost_mask)};
  end

  // sticky collection must never turn a non-zero value into zero
  always_comb begin
    if (sig_i != '0) AST_SHIFT_KEEPS_NONZERO: assert (sig_o != '0); // R8
  end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr
  import fpr_pkg::*;
(
  input  rmode_e            rm_i,
  input  logic              sign_i,
  input  logic [SIG_W-1:0]  sig_i,
  output logic [MANT_W:0]   mant_o,
  output logic              inexact_o
);
  logic lsb, g, st, up;

  assign lsb       = sig_i[EXT_W];
  assign g         = sig_i[EXT_W-1];
  assign st        = |sig_i[EXT_W-2:0];
  assign inexact_o = g | st;
  assign up        = rnd_up(rm_i, sign_i, lsb, g, st);
  assign mant_o    = {1'b0, sig_i[SIG_W-1:EXT_W]} + {{MANT_W{1'b0}}, up};

  // exact values are never altered
  always_comb begin
    if (!inexact_o) AST_EXACT_UNCHANGED: assert (mant_o[MANT_W-1:0] == sig_i[SIG_W-1:EXT_W]); // R8
  end
endmodule

// File: rtl/fp32_rounder.sv
module fp32_rounder
  import fpr_pkg::*;
#(
  parameter int     EXP_W  = 10,
  parameter bit     DYN_RM = 1'b1,
  parameter rmode_e RM_DEF = RM_NEAR_EVEN
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              rmode_i,
  input  logic                    nan_i,
  input  logic                    inf_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic [31:0]             result_o,
  output logic                    of_o,
  output logic                    uf_o,
  output logic                    nx_o
);
  rmode_e            rm;
  logic [SIG_W-1:0]  sig_d;
  logic              tiny;
  logic [MANT_W:0]   mant_r;
  logic              inexact;
  logic [EXP_W:0]    exp_n;
  logic              ovf;
  logic [31:0]       res_d;
  logic              of_d, uf_d, nx_d;

  generate
    if (DYN_RM) begin : g_dyn_rm
      assign rm = (rmode_i > 3'd4) ? RM_ZERO : rmode_e'(rmode_i);
    end else begin : g_static_rm
      assign rm = RM_DEF;
    end
  endgenerate

  fpr_denorm #(.EXP_W(EXP_W)) u_denorm (
    .exp_i  (exp_i),
    .sig_i  (sig_i),
    .sig_o  (sig_d),
    .tiny_o (tiny)
  );

  fpr_incr u_incr (
    .rm_i      (rm),
    .sign_i    (sign_i),
    .sig_i     (sig_d),
    .mant_o    (mant_r),
    .inexact_o (inexact)
  );

  // subnormal path: carry into hidden bit yields exponent field 1
  assign exp_n = tiny ? {{EXP_W{1'b0}}, mant_r[MANT_W-1]}
                      : {1'b0, exp_i} + {{EXP_W{1'b0}}, mant_r[MANT_W]};
  assign ovf   = exp_n >= (EXP_W+1)'(EXP_TOP);

  always_comb begin
    res_d = {sign_i, exp_n[EXPF_W-1:0], mant_r[FRAC_W-1:0]};
    of_d  = 1'b0;
    uf_d  = 1'b0;
    nx_d  = inexact;
    if (nan_i) begin
      res_d = 32'h7FC0_0000;
      nx_d  = 1'b0;
    end else if (inf_i) begin
      res_d = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      nx_d  = 1'b0;
    end else if (sig_i == '0) begin
      res_d = {sign_i, 31'd0};
      nx_d  = 1'b0;
    end else if (ovf) begin
      res_d = ovf_word(rm, sign_i);
      of_d  = 1'b1;
      nx_d  = 1'b1;
    end else begin
      uf_d  = (exp_n == '0) & inexact;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      of_o     <= 1'b0;
      uf_o     <= 1'b0;
      nx_o     <= 1'b0;
    end else begin
      result_o <= res_d;
      of_o     <= of_d;
      uf_o     <= uf_d;
      nx_o     <= nx_d;
    end
  end

  AST_OF_IMPLIES_NX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> nx_o); // R7
  AST_OF_ENCODING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> (result_o[30:0] == 31'h7F80_0000 || result_o[30:0] == 31'h7F7F_FFFF)); // R7
  AST_UF_IMPLIES_NX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> nx_o); // R9
  AST_UF_SUBNORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> (result_o[30:23] == 8'h00 && !of_o)); // R9
  AST_NAN_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[30:23] == 8'hFF && result_o[22:0] != '0) |-> !(of_o || uf_o || nx_o)); // R1
endmodule

// File: tb/tb_fp32_rounder.sv
module tb_fp32_rounder;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        rmode_i = '0;
  logic              nan_i = 1'b0, inf_i = 1'b0, sign_i = 1'b0;
  logic signed [9:0] exp_i = '0;
  logic [26:0]       sig_i = '0;
  logic [31:0]       result_o;
  logic              of_o, uf_o, nx_o;
  int                n_chk = 0, n_err = 0;
  bit                done = 1'b0;

  always #5 clk_i = ~clk_i;

  fp32_rounder dut (.*);

  // model: compare discarded remainder with half an ulp
  function automatic logic [34:0] model(int mode, bit s, int e, longint sig, bit nan, bit inf);
    int m, k, sh, ex;
    longint kept, rem, half;
    bit nx, up, of, uf, to_inf;
    logic [31:0] res;
    if (nan) return {32'h7FC00000, 3'b000};
    if (inf) return {s, 8'hFF, 23'd0, 3'b000};
    if (sig == 0) return {s, 31'd0, 3'b000};
    m = (mode > 4) ? 4 : mode;
    k = (e >= 1) ? 0 : 1 - e;
    if (k > 40) k = 40;
    sh = 3 + k;
    kept = sig >> sh;
    rem = sig - (kept << sh);
    half = longint'(1) << (sh - 1);
    nx = (rem != 0);
    case (m)
      0: up = (rem > half) || (rem == half && kept[0]);
      1: up = (rem >= half);
      2: up = !s && nx;
      3: up = s && nx;
      default: up = 0;
    endcase
    kept = kept + longint'(up);
    if (e >= 1) begin
      if (kept >= (longint'(1) << 24)) begin kept = kept >> 1; e = e + 1; end
      ex = e;
    end else ex = (kept >= (longint'(1) << 23)) ? 1 : 0;
    of = 0; uf = 0;
    if (ex >= 255) begin
      of = 1; nx = 1;
      to_inf = (m < 2) || (m == 2 && !s) || (m == 3 && s);
      res = to_inf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
    end else begin
      res = {s, ex[7:0], kept[22:0]};
      uf = (ex == 0) && nx;
    end
    return {res, of, uf, nx};
  endfunction

  task automatic check(string req, logic [34:0] exp_v);
    n_chk++;
    if ({result_o, of_o, uf_o, nx_o} !== exp_v) begin
      n_err++;
      $display("FAIL %s: got res=%08h of=%0b uf=%0b nx=%0b exp res=%08h of=%0b uf=%0b nx=%0b",
               req, result_o, of_o, uf_o, nx_o, exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic run(string req, int mode, bit s, int e, logic [26:0] sig, bit nan = 0, bit inf = 0);
    @(negedge clk_i);
    rmode_i = 3'(mode); sign_i = s; exp_i = 10'(e); sig_i = sig; nan_i = nan; inf_i = inf;
    @(negedge clk_i);
    check(req, model(mode, s, e, longint'(sig), nan, inf));
  endtask

  localparam logic [26:0] HALF15 = {24'hC00001, 3'b100};
  localparam logic [26:0] HALF05 = {24'hC00000, 3'b100};

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    #23;
    n_chk++;  // R11 reset state
    if ({result_o, of_o, uf_o, nx_o} !== 35'd0) begin
      n_err++;
      $display("FAIL R11: reset outputs %08h %b%b%b expected 0", result_o, of_o, uf_o, nx_o);
    end
    rst_ni = 1'b1;
    // R11 latency: output must not change before the edge
    @(negedge clk_i);
    rmode_i = 0; sign_i = 0; exp_i = 129; sig_i = HALF15;
    #2; n_chk++;
    if (result_o !== 32'd0) begin
      n_err++; $display("FAIL R11: early output %08h expected 00000000", result_o);
    end
    @(negedge clk_i);
    check("R11", {32'h40C00002, 3'b001});
    for (int md = 0; md < 8; md++) begin
      run("R3 R4 R5 R6 tie 1.5ulp +", md, 0, 129, HALF15);
      run("R3 R4 R5 R6 tie 1.5ulp -", md, 1, 129, HALF15);
      run("R3 R4 R5 R6 tie 0.5ulp +", md, 0, 129, HALF05);
      run("R3 R4 R5 R6 tie 0.5ulp -", md, 1, 129, HALF05);
      run("R7 R10 carry overflow +", md, 0, 254, 27'h7FFFFFF);
      run("R7 R10 carry overflow -", md, 1, 254, 27'h7FFFFFF);
      run("R7 large exponent +", md, 0, 300, {1'b1, 26'h1234567});
      run("R7 large exponent -", md, 1, 300, {1'b1, 26'h0});
      run("R9 deep underflow +", md, 0, -100, {1'b1, 26'h0});
      run("R9 deep underflow -", md, 1, -100, {1'b1, 26'h0});
      run("R10 subnormal carry", md, 0, 0, 27'h7FFFFFF);
      run("R8 R9 exact subnormal", md, 1, 0, {1'b1, 26'h0});
      run("R8 exact normal", md, 0, 127, {24'hABCDEF, 3'b000});
    end
    run("R1 nan", 2, 1, 300, 27'h7FFFFFF, 1, 1);
    run("R2 inf", 4, 1, 5, 27'h5555555, 0, 1);
    run("R2 zero", 3, 1, 77, 27'd0);
    for (int i = 0; i < 600; i++) begin
      int e;
      logic [26:0] sg;
      e  = int'($urandom_range(300)) - 40;
      sg = {1'b1, 26'($urandom)};
      if ($urandom_range(3) == 0) sg[2:0] = 3'b100;
      run("R3 R4 R5 R6 R7 R8 R9 random", int'($urandom_range(7)), 1'($urandom), e, sg,
          $urandom_range(40) == 0, $urandom_range(40) == 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule